// File: doc/BRIEF.md
# NAND Flash Transaction Sequencer

This block runs one complete NAND flash transaction on raw flash pins from a small set of host registers. The host loads a second-command word, a byte count, a column address and a page address, and then writes the first command word with its start bit set. From that single write the engine issues the command latch cycle, the address cycles and an optional second command. It waits a fixed settling time and then waits for the flash ready line. The data phase moves bytes between the flash and an internal byte buffer. A second command that belongs to a program operation is placed after the data instead of before the wait.

Command completion and data completion are reported as two separate sticky bits in an interrupt status register. The bits are cleared by writing 1 to them. A 32-bit mask turns any set status bit into an interrupt line. Strobe low time, strobe high time and the settling delay before ready is sampled are cycle-count parameters. A one-shot abort register returns the engine to idle. The host addresses 32-bit words: offsets 0 to 8 are registers, and an address with bit 5 set reaches byte buffer entry addr[3:0].

Top module: `nand_seq`

## Requirements
- R1: Writing word offset 0 (command word A) with bit 31 set while idle starts a transaction. The first bus cycle is a command latch (command latch high, write strobe pulsed) carrying bits 7:0. Bit 19 selects the chip: 0 drives fl_ce_n = 2'b10 and 1 drives fl_ce_n = 2'b01. Both enables are high when idle.
- R2: When command word A bit 30 is set, bits 29:27 hold the address cycle count minus one. Address byte k is byte k of {page[23:0], column[15:0]}, sent lowest byte first with address latch high, and bytes beyond the fifth are zero. The column register is at offset 3 and the page register at offset 4.
- R3: When bit 30 is clear, a read-direction transaction still issues exactly one address cycle, carrying column[7:0]. Any other transaction with bit 30 clear issues none.
- R4: Bit 26 selects a read data phase and bit 25 a write data phase. With neither bit set there is no data phase. A data phase makes exactly LENGTH strobes, where LENGTH is the value at offset 2 with no minus-one offset. Read byte k is stored in buffer entry k, and write byte k is taken from buffer entry k.
- R5: When bit 8 of command word B (offset 1) is set, its bits 7:0 are issued as a second command latch. For read and no-data transactions it follows the address cycles. For write transactions it follows the data bytes.
- R6: After the last command or data cycle, the engine waits T_WB cycles and then waits for fl_rb high. Only then does it start a read data phase or finish. No read strobe occurs while fl_rb is low.
- R7: Interrupt status (offset 5) bit 31 is set when a transaction completes. Bit 28 is set when its data phase completes, including one of zero bytes, and only for the read and write directions. Writing 1 to a bit clears it, and a set event in the same cycle wins.
- R8: irq is high exactly when some status bit is set whose bit in the mask register (offset 6) is also set.
- R9: A write to command word A while a transaction runs is ignored, and the register keeps its value. Offset 8 bit 0 reads 1 while a transaction runs.
- R10: Completion of a write-direction transaction clears command word B bit 30 and keeps its other bits. Other directions leave it unchanged.
- R11: Writing 1 to bit 0 of offset 7 returns the engine to idle at once. Both chip enables go high, strobes stop and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 6 | Host write word address (bit 5 selects buffer) |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 6 | Host read word address |
| host_rdata | output | 32 | Host read data, combinational |
| irq | output | 1 | Masked interrupt |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_ce_n | output | 2 | Chip enables, active low |
| fl_dq_out | output | 8 | Data bus driven value |
| fl_dq_oe | output | 1 | Data bus output enable |
| fl_dq_in | input | 8 | Data bus sampled value |
| fl_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The ready-line assertion assumes that the flash pulls fl_rb low only after a command latch and never during a data phase. The bench flash model holds ready low for a fixed time after each command latch and at no other time. The assertions also assume that command word B, the length and the address registers stay put while a transaction runs, and that the length does not exceed the buffer depth. The bench writes those registers only between transactions and keeps lengths at 16 or below; the only write it makes while busy goes to command word A.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD1, ST_ADDR, ST_DATA, ST_CMD2, ST_TWB, ST_RDY
    } seq_st_e;

    localparam logic [4:0] OFS_CMDA   = 5'd0;
    localparam logic [4:0] OFS_CMDB   = 5'd1;
    localparam logic [4:0] OFS_LEN    = 5'd2;
    localparam logic [4:0] OFS_COL    = 5'd3;
    localparam logic [4:0] OFS_PAGE   = 5'd4;
    localparam logic [4:0] OFS_STAT   = 5'd5;
    localparam logic [4:0] OFS_MASK   = 5'd6;
    localparam logic [4:0] OFS_ABORT  = 5'd7;
    localparam logic [4:0] OFS_ENGINE = 5'd8;

    localparam int STAT_CMD_DONE  = 31;
    localparam int STAT_DATA_DONE = 28;
endpackage

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [7:0]       rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [7:0]       rdata_b
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int T_PULSE = 2,
    parameter int T_HOLD  = 1,
    parameter int T_WB    = 3,
    localparam int CNT_W  = $clog2(T_PULSE + T_HOLD + T_WB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [7:0]       opcode1,
    input  logic [3:0]       addr_cnt,
    input  logic [63:0]      addr_bytes,
    input  logic             dir_rd,
    input  logic             dir_wr,
    input  logic             cs,
    input  logic             cmd2_en,
    input  logic [7:0]       cmd2_op,
    input  logic [LEN_W-1:0] len,
    input  logic             rb,
    input  logic [7:0]       dq_in,
    input  logic [7:0]       buf_rdata,
    output logic [LEN_W-1:0] buf_idx,
    output logic             buf_we,
    output logic             busy,
    output logic             cmd_done,
    output logic             data_done,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [1:0]       ce_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe
);
    localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(T_PULSE + T_HOLD - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] PULSE_CNT  = CNT_W'(T_PULSE);
    localparam logic [CNT_W-1:0] WB_LAST    = CNT_W'(T_WB - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] idx;
    } fsm_t;

    fsm_t    q, d;
    logic    op_last;
    seq_st_e after_wdata, after_addr;
    logic    wr_empty;

    always_comb begin
        d         = q;
        buf_we    = 1'b0;
        cmd_done  = 1'b0;
        data_done = 1'b0;
        op_last   = (q.cnt == OP_LAST);
        wr_empty  = dir_wr && (len == '0);
        after_wdata = cmd2_en ? ST_CMD2 : ST_TWB;
        after_addr  = (dir_wr && len != '0) ? ST_DATA : after_wdata;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st  = ST_CMD1;
                d.cnt = '0;
                d.idx = '0;
            end
            ST_CMD1: begin
                d.cnt = q.cnt + 1'b1;
                if (op_last) begin
                    d.cnt = '0;
                    d.idx = '0;
                    if (addr_cnt != 4'd0) d.st = ST_ADDR;
                    else begin
                        d.st      = after_addr;
                        data_done = wr_empty;
                    end
                end
            end
            ST_ADDR: begin
                d.cnt = q.cnt + 1'b1;
                if (op_last) begin
                    d.cnt = '0;
                    if (q.idx == LEN_W'(addr_cnt - 4'd1)) begin
                        d.idx     = '0;
                        d.st      = after_addr;
                        data_done = wr_empty;
                    end else d.idx = q.idx + 1'b1;
                end
            end
            ST_DATA: begin
                d.cnt  = q.cnt + 1'b1;
                buf_we = dir_rd && (q.cnt == PULSE_LAST);
                if (op_last) begin
                    d.cnt = '0;
                    if (q.idx == len - 1'b1) begin
                        d.idx     = '0;
                        data_done = 1'b1;
                        if (dir_wr) d.st = after_wdata;
                        else begin
                            d.st     = ST_IDLE;
                            cmd_done = 1'b1;
                        end
                    end else d.idx = q.idx + 1'b1;
                end
            end
            ST_CMD2: begin
                d.cnt = q.cnt + 1'b1;
                if (op_last) begin
                    d.cnt = '0;
                    d.st  = ST_TWB;
                end
            end
            ST_TWB: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == WB_LAST) begin
                    d.cnt = '0;
                    d.st  = ST_RDY;
                end
            end
            ST_RDY: if (rb) begin
                d.cnt = '0;
                d.idx = '0;
                if (dir_rd && len != '0) d.st = ST_DATA;
                else begin
                    d.st      = ST_IDLE;
                    cmd_done  = 1'b1;
                    data_done = dir_rd;
                end
            end
            default: d = '0;
        endcase
        if (abort) begin
            d         = '0;
            cmd_done  = 1'b0;
            data_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic drive, low_phase;
    assign low_phase = (q.cnt < PULSE_CNT);
    assign drive     = (q.st == ST_CMD1) || (q.st == ST_CMD2) || (q.st == ST_ADDR)
                    || (q.st == ST_DATA && dir_wr);
    assign busy    = (q.st != ST_IDLE);
    assign cle     = (q.st == ST_CMD1) || (q.st == ST_CMD2);
    assign ale     = (q.st == ST_ADDR);
    assign we_n    = !(drive && low_phase);
    assign re_n    = !(q.st == ST_DATA && dir_rd && low_phase);
    assign dq_oe   = drive;
    assign ce_n    = !busy ? 2'b11 : (cs ? 2'b01 : 2'b10);
    assign buf_idx = q.idx;
    assign dq_out  = (q.st == ST_CMD1) ? opcode1 :
                     (q.st == ST_CMD2) ? cmd2_op :
                     (q.st == ST_ADDR) ? addr_bytes[{q.idx[2:0], 3'b000} +: 8] :
                     buf_rdata;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R4
    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R2
    AST_READ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> rb); // R6
    AST_DATA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA) |-> (q.idx < len)); // R4
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && ce_n == 2'b11 && we_n && re_n)); // R11
    AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_n) <= 1); // R1
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int LEN_W     = 8,
    parameter int T_PULSE   = 2,
    parameter int T_HOLD    = 1,
    parameter int T_WB      = 3,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [5:0]  host_waddr,
    input  logic [31:0] host_wdata,
    input  logic [5:0]  host_raddr,
    output logic [31:0] host_rdata,
    output logic        irq,
    output logic        fl_cle,
    output logic        fl_ale,
    output logic        fl_we_n,
    output logic        fl_re_n,
    output logic [1:0]  fl_ce_n,
    output logic [7:0]  fl_dq_out,
    output logic        fl_dq_oe,
    input  logic [7:0]  fl_dq_in,
    input  logic        fl_rb
);
    typedef struct packed {
        logic [31:0]      ctl1;
        logic [31:0]      ctl2;
        logic [LEN_W-1:0] len;
        logic [15:0]      col;
        logic [23:0]      page;
        logic [31:0]      stat;
        logic [31:0]      mask;
    } regs_t;

    regs_t q, d;
    logic start, abort, busy, cmd_done, data_done, eng_we, reg_we;
    logic [LEN_W-1:0] eng_idx;
    logic [7:0] buf_host_rd, buf_eng_rd;
    logic [3:0] addr_cnt;

    assign reg_we = host_we && !host_waddr[5];

    always_comb begin
        d     = q;
        start = 1'b0;
        abort = 1'b0;
        if (reg_we) begin
            case (host_waddr[4:0])
                OFS_CMDA: if (!busy) begin
                    d.ctl1 = host_wdata;
                    start  = host_wdata[31];
                end
                OFS_CMDB:  d.ctl2 = host_wdata;
                OFS_LEN:   d.len  = host_wdata[LEN_W-1:0];
                OFS_COL:   d.col  = host_wdata[15:0];
                OFS_PAGE:  d.page = host_wdata[23:0];
                OFS_STAT:  d.stat = q.stat & ~host_wdata;
                OFS_MASK:  d.mask = host_wdata;
                OFS_ABORT: abort  = host_wdata[0];
                default: ;
            endcase
        end
        if (cmd_done)  d.stat[STAT_CMD_DONE]  = 1'b1;
        if (data_done) d.stat[STAT_DATA_DONE] = 1'b1;
        if (cmd_done && q.ctl1[25]) d.ctl2[30] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // address cycle count: explicit field, else one for a read, else none
    assign addr_cnt = q.ctl1[30] ? ({1'b0, q.ctl1[29:27]} + 4'd1)
                                 : (q.ctl1[26] ? 4'd1 : 4'd0);

    nand_seq_fsm #(
        .LEN_W(LEN_W), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_WB(T_WB)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .opcode1(q.ctl1[7:0]), .addr_cnt(addr_cnt),
        .addr_bytes({24'b0, q.page, q.col}),
        .dir_rd(q.ctl1[26]), .dir_wr(q.ctl1[25]), .cs(q.ctl1[19]),
        .cmd2_en(q.ctl2[8]), .cmd2_op(q.ctl2[7:0]), .len(q.len),
        .rb(fl_rb), .dq_in(fl_dq_in), .buf_rdata(buf_eng_rd),
        .buf_idx(eng_idx), .buf_we(eng_we), .busy(busy),
        .cmd_done(cmd_done), .data_done(data_done),
        .cle(fl_cle), .ale(fl_ale), .we_n(fl_we_n), .re_n(fl_re_n),
        .ce_n(fl_ce_n), .dq_out(fl_dq_out), .dq_oe(fl_dq_oe)
    );

    nand_seq_buf #(.DEPTH(BUF_DEPTH)) i_buf (
        .clk(clk),
        .we(eng_we || (host_we && host_waddr[5])),
        .waddr(eng_we ? eng_idx[IDX_W-1:0] : host_waddr[IDX_W-1:0]),
        .wdata(eng_we ? fl_dq_in : host_wdata[7:0]),
        .raddr_a(host_raddr[IDX_W-1:0]), .rdata_a(buf_host_rd),
        .raddr_b(eng_idx[IDX_W-1:0]), .rdata_b(buf_eng_rd)
    );

    always_comb begin
        host_rdata = '0;
        if (host_raddr[5]) host_rdata = {24'b0, buf_host_rd};
        else begin
            case (host_raddr[4:0])
                OFS_CMDA:   host_rdata = q.ctl1;
                OFS_CMDB:   host_rdata = q.ctl2;
                OFS_LEN:    host_rdata = 32'(q.len);
                OFS_COL:    host_rdata = {16'b0, q.col};
                OFS_PAGE:   host_rdata = {8'b0, q.page};
                OFS_STAT:   host_rdata = q.stat;
                OFS_MASK:   host_rdata = q.mask;
                OFS_ENGINE: host_rdata = {31'b0, busy};
                default:    host_rdata = '0;
            endcase
        end
    end

    assign irq = |(q.stat & q.mask);

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && host_waddr[4:0] == OFS_CMDA) |=> $stable(q.ctl1)); // R9
    AST_W1C_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && host_waddr[4:0] == OFS_STAT && host_wdata[STAT_DATA_DONE] && !data_done)
        |=> !q.stat[STAT_DATA_DONE]); // R7
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> q.stat[STAT_CMD_DONE]); // R7
endmodule

// File: tb/test_nand_seq.sv
module test_nand_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic [5:0]  host_raddr = '0;
    logic [31:0] host_rdata;
    logic        irq, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
    logic [1:0]  fl_ce_n;
    logic [7:0]  fl_dq_out, fl_dq_in;
    logic        fl_rb;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    nand_seq i_nand_seq (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .irq(irq), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
        .fl_re_n(fl_re_n), .fl_ce_n(fl_ce_n), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rb(fl_rb)
    );

    // flash model and bus recorder, all at the falling clock edge
    localparam int FL_BUSY = 6;
    int rec_n = 0;
    logic [1:0] rec_kind [64];
    logic [7:0] rec_val  [64];
    logic [1:0] rec_ce   [64];
    int re_pulses = 0;
    int re_while_busy = 0;
    int busy_cnt = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    assign fl_rb    = (busy_cnt == 0);
    assign fl_dq_in = 8'h30 + re_pulses[7:0];

    always @(negedge clk) begin
        if (!prev_we && fl_we_n) begin
            if (rec_n < 64) begin
                rec_kind[rec_n] = fl_cle ? 2'd0 : (fl_ale ? 2'd1 : 2'd2);
                rec_val[rec_n]  = fl_dq_out;
                rec_ce[rec_n]   = fl_ce_n;
            end
            rec_n++;
            if (fl_cle) busy_cnt = FL_BUSY;
        end else if (busy_cnt > 0) busy_cnt--;
        if (!prev_re && fl_re_n) re_pulses++;
        if (!fl_re_n && busy_cnt != 0) re_while_busy++;
        prev_we = fl_we_n;
        prev_re = fl_re_n;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        host_raddr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int guard = 0;
        rd(6'd8, v);
        while (v[0] && guard < 4000) begin
            rd(6'd8, v);
            guard++;
        end
        check(!v[0], req, v, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] wpat(input int k);
        return 8'h50 + 8'(k * 3);
    endfunction

    logic [1:0] exp_kind [64];
    logic [7:0] exp_val  [64];
    int exp_n;

    // dir: 0 none, 1 read, 2 write
    task automatic run_tx(input int dir, input int na, input bit aflag, input bit c2,
                          input bit cs, input int len, input bit poke, input string tag);
        logic [31:0] c1, c2w, v;
        logic [15:0] col;
        logic [23:0] page;
        logic [39:0] a40;
        logic [7:0]  opc;
        logic [1:0]  ece;
        int nad, bad;
        bit ok;
        opc  = 8'h10 + 8'(na) + 8'(dir * 8);
        col  = 16'hC3A5 ^ 16'(na * 16'h0101);
        page = 24'h5A1E70 + 24'(na);
        a40  = {page, col};
        ece  = cs ? 2'b01 : 2'b10;
        c1 = '0;
        c1[31] = 1'b1; c1[30] = aflag; c1[29:27] = 3'(na - 1);
        c1[26] = (dir == 1); c1[25] = (dir == 2); c1[19] = cs; c1[7:0] = opc;
        c2w = 32'h6800_00E0 | (c2 ? 32'h100 : 32'h0);
        if (dir == 2) for (int k = 0; k < len; k++) wr(6'h20 | 6'(k), {24'b0, wpat(k)});
        wr(6'd1, c2w);
        wr(6'd2, 32'(len));
        wr(6'd3, {16'b0, col});
        wr(6'd4, {8'b0, page});
        wr(6'd5, 32'hFFFF_FFFF);
        // expected bus sequence
        exp_n = 0;
        exp_kind[exp_n] = 2'd0; exp_val[exp_n] = opc; exp_n++;
        nad = aflag ? na : ((dir == 1) ? 1 : 0);
        for (int k = 0; k < nad; k++) begin
            exp_kind[exp_n] = 2'd1;
            exp_val[exp_n]  = (k < 5) ? a40[8*k +: 8] : 8'h00;
            exp_n++;
        end
        if (dir == 2) for (int k = 0; k < len; k++) begin
            exp_kind[exp_n] = 2'd2; exp_val[exp_n] = wpat(k); exp_n++;
        end
        if (c2) begin
            exp_kind[exp_n] = 2'd0; exp_val[exp_n] = 8'hE0; exp_n++;
        end
        @(negedge clk);
        rec_n = 0; re_pulses = 0; re_while_busy = 0;
        wr(6'd0, c1);
        if (poke) begin
            rd(6'd8, v);
            check(v[0] == 1'b1, {tag, " R9 busy bit while running"}, v, 32'd1);
            wr(6'd0, 32'h8000_00AA);
        end
        wait_idle({tag, " R6 completes"});
        ok = (rec_n == exp_n);
        bad = -1;
        if (ok) for (int k = 0; k < exp_n; k++)
            if (bad < 0 && (rec_kind[k] != exp_kind[k] || rec_val[k] != exp_val[k] || rec_ce[k] != ece))
                bad = k;
        if (!ok) check(0, {tag, " R1 R2 R3 R5 R9 cycle count"}, 32'(rec_n), 32'(exp_n));
        else if (bad >= 0)
            check(0, {tag, " R1 R2 R3 R5 bus cycle"}, {14'b0, rec_ce[bad], 6'b0, rec_kind[bad], rec_val[bad]},
                  {14'b0, ece, 6'b0, exp_kind[bad], exp_val[bad]});
        else check(1, {tag, " R1 R2 R5 bus sequence"}, 0, 0);
        check(re_pulses == ((dir == 1) ? len : 0), {tag, " R4 read strobe count"},
              32'(re_pulses), 32'((dir == 1) ? len : 0));
        check(re_while_busy == 0, {tag, " R6 read strobe while busy"}, 32'(re_while_busy), 0);
        rd(6'd5, v);
        check(v == ((dir == 0) ? 32'h8000_0000 : 32'h9000_0000), {tag, " R7 status"}, v,
              (dir == 0) ? 32'h8000_0000 : 32'h9000_0000);
        rd(6'd1, v);
        check(v == ((dir == 2) ? (c2w & ~32'h4000_0000) : c2w), {tag, " R10 word B after"}, v,
              (dir == 2) ? (c2w & ~32'h4000_0000) : c2w);
        if (poke) begin
            rd(6'd0, v);
            check(v == c1, {tag, " R9 word A unchanged"}, v, c1);
        end
        if (dir == 1) for (int k = 0; k < len; k++) begin
            rd(6'h20 | 6'(k), v);
            check(v[7:0] == 8'h30 + 8'(k), {tag, " R4 read byte stored"}, v, 32'h30 + 32'(k));
        end
        check(fl_ce_n == 2'b11, {tag, " R1 chip enables idle"}, {30'b0, fl_ce_n}, 32'd3);
    endtask

    initial begin
        logic [31:0] v;
        int hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        rd(6'd5, v); check(v == 0, "R7 status after reset", v, 0);
        rd(6'd8, v); check(v == 0, "R9 engine idle after reset", v, 0);
        check(irq == 1'b0, "R8 irq after reset", {31'b0, irq}, 0);
        check(fl_ce_n == 2'b11 && fl_we_n && fl_re_n, "R1 pins after reset",
              {28'b0, fl_ce_n, fl_we_n, fl_re_n}, 32'hF);

        // sweep direction x address count x second command
        for (int dir = 0; dir < 3; dir++)
            for (int na = 1; na <= 5; na++)
                for (int c2 = 0; c2 < 2; c2++)
                    run_tx(dir, na, 1'b1, c2[0], na[0], na + 2 + c2 * 6, 1'b0, "sweep");

        // address flag clear
        run_tx(1, 3, 1'b0, 1'b1, 1'b0, 4, 1'b0, "R3 read no addr field");
        run_tx(0, 3, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R3 none no addr field");
        run_tx(2, 3, 1'b0, 1'b0, 1'b0, 2, 1'b0, "R3 write no addr field");
        // maximum encoded count, zero-length data and full buffer
        run_tx(0, 8, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R2 eight cycles");
        run_tx(1, 2, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R4 read zero length");
        run_tx(2, 2, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R4 write zero length");
        run_tx(1, 5, 1'b1, 1'b1, 1'b0, 16, 1'b0, "R4 read full buffer");
        run_tx(2, 5, 1'b1, 1'b1, 1'b1, 16, 1'b0, "R4 write full buffer");
        // start while busy is ignored
        run_tx(1, 4, 1'b1, 1'b1, 1'b1, 10, 1'b1, "R9 poke");

        // interrupt masking and write-1-to-clear (status holds 31 and 28 from the last read)
        wr(6'd6, 32'h0);
        check(irq == 1'b0, "R8 all masked", {31'b0, irq}, 0);
        wr(6'd6, 32'h1000_0000);
        check(irq == 1'b1, "R8 data-done unmasked", {31'b0, irq}, 1);
        wr(6'd5, 32'h1000_0000);
        rd(6'd5, v); check(v == 32'h8000_0000, "R7 clear bit 28 only", v, 32'h8000_0000);
        check(irq == 1'b0, "R8 irq after clearing masked bit", {31'b0, irq}, 0);
        wr(6'd6, 32'h8000_0000);
        check(irq == 1'b1, "R8 cmd-done unmasked", {31'b0, irq}, 1);
        wr(6'd5, 32'h8000_0000);
        rd(6'd5, v); check(v == 0, "R7 clear bit 31", v, 0);
        check(irq == 1'b0, "R8 irq after full clear", {31'b0, irq}, 0);

        // abort in the middle of a write data phase
        wr(6'd1, 32'h0000_0000);
        wr(6'd2, 32'd16);
        wr(6'd5, 32'hFFFF_FFFF);
        wr(6'd0, 32'hC200_0080);
        repeat (12) @(negedge clk);
        wr(6'd7, 32'h1);
        rd(6'd8, v); check(v == 0, "R11 idle after abort", v, 0);
        check(fl_ce_n == 2'b11, "R11 enables high after abort", {30'b0, fl_ce_n}, 3);
        hold = rec_n;
        repeat (40) @(negedge clk);
        check(rec_n == hold, "R11 no strobes after abort", 32'(rec_n), 32'(hold));
        rd(6'd5, v); check(v == 0, "R11 no status after abort", v, 0);
        // engine usable again
        run_tx(1, 2, 1'b1, 1'b1, 1'b0, 5, 1'b0, "R11 restart");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule